// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Controller

This block gives every hart in a small cluster two interrupt sources: a software flag that any agent on the register bus can raise or clear, and a timer that fires once a shared, free-running 64-bit counter passes a per-hart 64-bit threshold. The number of harts is a parameter. All harts watch the same counter, so one write to the counter moves the time base for the whole cluster.

Software reaches the block through a plain 32-bit register port: a select, a write enable, a 16-bit byte offset inside a 64 KiB window, write data, combinational read data and an error flag. The 64-bit registers are reached as two 32-bit words. The block drives one timer-pending line and one software-pending line per hart. These lines are level signals that the hart's interrupt logic samples directly.

Top module: `hart_timer_irq`

## Requirements
- R1: After reset the counter and every software word read zero, every threshold reads all ones in both words, and all pending outputs are low.
- R2: The software word of hart h sits at offset 4*h (offsets below 0x4000). It holds the full 32 bits written and reads back unchanged. The software-pending output of hart h is high exactly when that word is nonzero.
- R3: The threshold of hart h sits at offset 0x4000 + 8*h. Offset bit 2 picks the word: clear for bits 31:0, set for bits 63:32. A write replaces only the addressed word and leaves the other word unchanged.
- R4: The counter is read and written at 0xBFF8 (bits 31:0) and 0xBFFC (bits 63:32). A write replaces only the addressed word.
- R5: The counter increases by exactly one on each clock edge while tick_en is high. It holds its value while tick_en is low. A carry out of the low word passes into the high word.
- R6: A counter write on an edge where tick_en is high stores the written word. The other word keeps its pre-edge value, and no increment is applied on that edge.
- R7: The timer-pending output of hart h is high only when the counter is strictly greater than that hart's threshold. Equality gives low.
- R8: A selected access at offset 0xC000 or above raises bus_err in the same cycle and reads zero. A write there changes no state. Offsets below 0xC000 never raise bus_err.
- R9: Software words or thresholds addressed to a hart index at or above NUM_HARTS read zero, ignore writes and do not raise bus_err.
- R10: Offset bits 1:0 are ignored. Every access moves one whole 32-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter increment enable for this cycle |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write when high, a read when low |
| bus_addr | input | 16 | Byte offset inside the 64 KiB window |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, combinational from bus_addr |
| bus_err | output | 1 | Access fault for the offset in bus_addr |
| timer_irq | output | NUM_HARTS | Per-hart timer pending |
| soft_irq | output | NUM_HARTS | Per-hart software pending |

## Verification
The properties take bus_addr, bus_we and bus_wdata to be meaningful only while bus_sel is high, and they take tick_en to be a plain per-cycle level. They also take NUM_HARTS to be no greater than the hart index range of either region. The stimulus changes every input only at the falling clock edge, so each rising edge sees one settled access. It draws hart indices from just past NUM_HARTS, so the unpopulated slots are exercised without leaving the decoded window by accident. Threshold writes are steered close to the running counter, so the strict comparison actually switches during random runs.

// File: rtl/hart_irq_pkg.sv
`timescale 1ns/1ps
package hart_irq_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 32;
    localparam int CNT_W  = 64;
    localparam int IDX_W_MAX = 12;

    localparam logic [BUS_AW-1:0] CMP_BASE  = 16'h4000;
    localparam logic [BUS_AW-1:0] TIME_BASE = 16'hBFF8;
    localparam logic [BUS_AW-1:0] TIME_LAST = 16'hBFFF;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SOFT = 2'd1,
        REG_CMP  = 2'd2,
        REG_TIME = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [IDX_W_MAX-1:0]   idx;
        logic                   hi;
    } bus_dec_t;

    function automatic logic [CNT_W-1:0] put_word(input logic [CNT_W-1:0] old,
                                                  input logic hi,
                                                  input logic [BUS_DW-1:0] d);
        return hi ? {d, old[BUS_DW-1:0]} : {old[CNT_W-1:BUS_DW], d};
    endfunction

    function automatic logic [BUS_DW-1:0] get_word(input logic [CNT_W-1:0] v,
                                                   input logic hi);
        return hi ? v[CNT_W-1:BUS_DW] : v[BUS_DW-1:0];
    endfunction

endpackage

// File: rtl/hart_bus_decode.sv
`timescale 1ns/1ps
module hart_bus_decode
    import hart_irq_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic [BUS_AW-1:0] addr,
    output bus_dec_t          dec,
    output logic              idx_ok
);

    always_comb begin
        dec = '{kind: REG_NONE, idx: '0, hi: addr[2]};
        if (addr < CMP_BASE) begin
            dec.kind = REG_SOFT;
            dec.idx  = IDX_W_MAX'(addr >> 2);
        end else if (addr < TIME_BASE) begin
            dec.kind = REG_CMP;
            dec.idx  = IDX_W_MAX'((addr - CMP_BASE) >> 3);
        end else if (addr <= TIME_LAST) begin
            dec.kind = REG_TIME;
        end
        idx_ok = ((dec.kind == REG_SOFT) || (dec.kind == REG_CMP))
                 && (32'(dec.idx) < NUM_HARTS);
    end

endmodule

// File: rtl/hart_time_counter.sv
`timescale 1ns/1ps
module hart_time_counter
    import hart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BUS_DW-1:0] wr_data,
    output logic [CNT_W-1:0]  time_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= put_word(cnt_q, wr_hi, wr_data);
        end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign time_o = cnt_q;

endmodule

// File: rtl/hart_slot.sv
`timescale 1ns/1ps
module hart_slot
    import hart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic              cmp_we,
    input  logic              wr_hi,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic [CNT_W-1:0]  time_i,
    output logic [BUS_DW-1:0] sw_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              tip_o,
    output logic              sip_o
);

    logic [BUS_DW-1:0] sw_q;
    logic [CNT_W-1:0]  cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else if (sw_we) begin
            sw_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
        end else if (cmp_we) begin
            cmp_q <= put_word(cmp_q, wr_hi, wr_data);
        end
    end

    assign sw_o  = sw_q;
    assign cmp_o = cmp_q;
    assign tip_o = (time_i > cmp_q);
    assign sip_o = (sw_q != '0);

endmodule

// File: rtl/hart_timer_irq.sv
`timescale 1ns/1ps
module hart_timer_irq
    import hart_irq_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_err,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);

    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    bus_dec_t          dec;
    logic              idx_ok;
    logic              wr_go;
    logic [CNT_W-1:0]  time_q;
    logic [BUS_DW-1:0] sw_val  [NUM_HARTS];
    logic [CNT_W-1:0]  cmp_val [NUM_HARTS];
    logic [IDX_W-1:0]  rd_idx;

    assign wr_go  = bus_sel & bus_we;
    assign rd_idx = dec.idx[IDX_W-1:0];

    hart_bus_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
        .addr   (bus_addr),
        .dec    (dec),
        .idx_ok (idx_ok)
    );

    hart_time_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (wr_go && (dec.kind == REG_TIME)),
        .wr_hi   (dec.hi),
        .wr_data (bus_wdata),
        .time_o  (time_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
        logic hit;
        assign hit = wr_go && idx_ok && (dec.idx == IDX_W_MAX'(h));

        hart_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .sw_we   (hit && (dec.kind == REG_SOFT)),
            .cmp_we  (hit && (dec.kind == REG_CMP)),
            .wr_hi   (dec.hi),
            .wr_data (bus_wdata),
            .time_i  (time_q),
            .sw_o    (sw_val[h]),
            .cmp_o   (cmp_val[h]),
            .tip_o   (timer_irq[h]),
            .sip_o   (soft_irq[h])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (dec.kind)
            REG_SOFT: if (idx_ok) bus_rdata = sw_val[rd_idx];
            REG_CMP:  if (idx_ok) bus_rdata = get_word(cmp_val[rd_idx], dec.hi);
            REG_TIME: bus_rdata = get_word(time_q, dec.hi);
            default:  bus_rdata = '0;
        endcase
    end

    assign bus_err = bus_sel && (dec.kind == REG_NONE);

endmodule

// File: rtl/hart_timer_irq_chk.sv
`timescale 1ns/1ps
module hart_timer_irq_chk #(
    parameter int NUM_HARTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_en,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [15:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 bus_err,
    input logic [NUM_HARTS-1:0] soft_irq,
    input logic [63:0]          time_cnt
);

    logic time_wr;
    assign time_wr = bus_sel && bus_we && (bus_addr[15:3] == 13'h17FF);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !time_wr) |=> (time_cnt == $past(time_cnt) + 64'd1));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !time_wr) |=> $stable(time_cnt));

    // R6
    cnt_wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr[15:2] == 14'h2FFE)
        |=> (time_cnt[31:0] == $past(bus_wdata)));

    // R6
    cnt_wr_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr[15:2] == 14'h2FFF)
        |=> (time_cnt[63:32] == $past(bus_wdata)));

    // R8
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr >= 16'hC000) |-> (bus_err && bus_rdata == 32'd0));

    // R8
    no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr < 16'hC000) |-> !bus_err);

    // R8
    fault_wr_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr >= 16'hC000) |=> $stable(soft_irq));

    // R9
    absent_sw_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr < 16'h4000 && 32'(bus_addr[15:2]) >= NUM_HARTS)
        |-> (bus_rdata == 32'd0));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
        // R2
        sw_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_we && bus_addr[15:2] == 14'(h))
            |=> (soft_irq[h] == ($past(bus_wdata) != 32'd0)));
    end

endmodule

bind hart_timer_irq hart_timer_irq_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .soft_irq  (soft_irq),
    .time_cnt  (time_q)
);

// File: tb/hart_timer_irq_bench.sv
`timescale 1ns/1ps
module hart_timer_irq_bench;

    localparam int NH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          b_tick = 1'b0;
    logic          b_sel = 1'b0;
    logic          b_we = 1'b0;
    logic [15:0]   b_addr = '0;
    logic [31:0]   b_wd = '0;
    logic [31:0]   rdata;
    logic          err;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hart_timer_irq #(.NUM_HARTS(NH)) u_hart_timer_irq (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (b_tick),
        .bus_sel   (b_sel),
        .bus_we    (b_we),
        .bus_addr  (b_addr),
        .bus_wdata (b_wd),
        .bus_rdata (rdata),
        .bus_err   (err),
        .timer_irq (timer_irq),
        .soft_irq  (soft_irq)
    );

    // reference model, updated from the same inputs the design sees
    logic [63:0] m_time;
    logic [31:0] m_sw  [NH];
    logic [63:0] m_cmp [NH];
    logic        t_wr;
    int          wi;

    always @(posedge clk) begin
        if (rst) begin
            m_time = '0;
            for (int i = 0; i < NH; i++) begin
                m_sw[i]  = '0;
                m_cmp[i] = '1;
            end
        end else begin
            t_wr = 1'b0;
            if (b_sel && b_we) begin
                if (b_addr < 16'h4000) begin
                    wi = int'(b_addr >> 2);
                    if (wi < NH) m_sw[wi] = b_wd;
                end else if (b_addr < 16'hBFF8) begin
                    wi = int'((b_addr - 16'h4000) >> 3);
                    if (wi < NH) begin
                        if (b_addr[2]) m_cmp[wi][63:32] = b_wd;
                        else           m_cmp[wi][31:0]  = b_wd;
                    end
                end else if (b_addr <= 16'hBFFF) begin
                    t_wr = 1'b1;
                    if (b_addr[2]) m_time[63:32] = b_wd;
                    else           m_time[31:0]  = b_wd;
                end
            end
            if (!t_wr && b_tick) m_time = m_time + 64'd1;
        end
    end

    function automatic logic [32:0] model_rd(input logic [15:0] a);
        int i;
        if (a < 16'h4000) begin
            i = int'(a >> 2);
            return {1'b0, (i < NH) ? m_sw[i] : 32'd0};
        end else if (a < 16'hBFF8) begin
            i = int'((a - 16'h4000) >> 3);
            if (i >= NH) return 33'd0;
            return {1'b0, a[2] ? m_cmp[i][63:32] : m_cmp[i][31:0]};
        end else if (a <= 16'hBFFF) begin
            return {1'b0, a[2] ? m_time[63:32] : m_time[31:0]};
        end
        return {1'b1, 32'd0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        b_sel = 1'b1; b_we = 1'b1; b_addr = a; b_wd = d;
        @(negedge clk);
        b_sel = 1'b0; b_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input string req);
        logic [32:0] e;
        @(negedge clk);
        b_sel = 1'b1; b_we = 1'b0; b_addr = a;
        #1;
        e = model_rd(a);
        chk(req, {32'd0, rdata}, {32'd0, e[31:0]});
        chk(req, {63'd0, err}, {63'd0, e[32]});
        b_sel = 1'b0;
    endtask

    task automatic irq_chk(input string req);
        logic [NH-1:0] et, es;
        @(negedge clk);
        #1;
        for (int h = 0; h < NH; h++) begin
            et[h] = (m_time > m_cmp[h]);
            es[h] = (m_sw[h] != 32'd0);
        end
        chk(req, 64'(timer_irq), 64'(et));
        chk(req, 64'(soft_irq), 64'(es));
    endtask

    initial begin
        #1_600_000;
        n_chk++; n_bad++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values, checked against constants
        @(negedge clk); #1;
        chk("R1", 64'(timer_irq), 64'd0);
        chk("R1", 64'(soft_irq), 64'd0);
        b_sel = 1'b1; b_addr = 16'h4000; #1;
        chk("R1", 64'(rdata), 64'hFFFF_FFFF);
        b_addr = 16'h4004; #1;
        chk("R1", 64'(rdata), 64'hFFFF_FFFF);
        b_addr = 16'hBFF8; #1;
        chk("R1", 64'(rdata), 64'd0);
        b_addr = 16'h0008; #1;
        chk("R1", 64'(rdata), 64'd0);
        b_sel = 1'b0;

        // R2: full word stored, any nonzero bit raises the flag
        bus_wr(16'h0004, 32'h8000_0000);
        rd_chk(16'h0004, "R2");
        irq_chk("R2");
        chk("R2", 64'(soft_irq), 64'b0010);
        bus_wr(16'h0004, 32'd0);
        irq_chk("R2");

        // R3: word select in threshold
        bus_wr(16'h4008, 32'h1111_2222);
        rd_chk(16'h4008, "R3");
        rd_chk(16'h400C, "R3");
        bus_wr(16'h400C, 32'h0000_0007);
        rd_chk(16'h4008, "R3");

        // R4 and R10: counter words, low offset bits ignored
        bus_wr(16'hBFFC, 32'h0000_0005);
        rd_chk(16'hBFF8, "R4");
        rd_chk(16'hBFFE, "R10");
        bus_wr(16'h000D, 32'h0000_00A5);
        rd_chk(16'h000C, "R10");

        // R7: strict comparison, equality stays low
        bus_wr(16'hBFF8, 32'h0000_0100);
        bus_wr(16'h4010, 32'h0000_0100);
        bus_wr(16'h4014, 32'h0000_0005);
        irq_chk("R7");
        chk("R7", 64'(timer_irq[2]), 64'd0);
        bus_wr(16'hBFF8, 32'h0000_0101);
        irq_chk("R7");
        chk("R7", 64'(timer_irq[2]), 64'd1);
        bus_wr(16'hBFF8, 32'h0000_00FF);
        irq_chk("R7");

        // R5: counting, carry from low to high word
        bus_wr(16'hBFF8, 32'hFFFF_FFFE);
        b_tick = 1'b1;
        for (int k = 0; k < 6; k++) begin
            rd_chk(16'hBFF8, "R5");
            rd_chk(16'hBFFC, "R5");
        end
        b_tick = 1'b0;
        rd_chk(16'hBFF8, "R5");
        rd_chk(16'hBFF8, "R5");

        // R6: write beats increment
        b_tick = 1'b1;
        bus_wr(16'hBFF8, 32'h0000_0042);
        b_tick = 1'b0;
        rd_chk(16'hBFF8, "R6");
        chk("R6", 64'(rdata), 64'h42);

        // R8: fault region
        rd_chk(16'hC000, "R8");
        rd_chk(16'hFFFC, "R8");
        rd_chk(16'hBFFC, "R8");
        bus_wr(16'hC004, 32'hDEAD_BEEF);
        rd_chk(16'hBFF8, "R8");
        irq_chk("R8");

        // R9: absent harts
        bus_wr(16'h0010, 32'h1);
        rd_chk(16'h0010, "R9");
        irq_chk("R9");
        bus_wr(16'h4020, 32'h0);
        rd_chk(16'h4020, "R9");
        irq_chk("R9");

        // random mix
        for (int k = 0; k < 600; k++) begin
            int op, h;
            logic [31:0] d;
            b_tick = 1'($urandom_range(0, 1));
            op = int'($urandom_range(0, 9));
            h  = int'($urandom_range(0, NH + 1));
            case (op)
                0, 1: begin
                    d = ($urandom_range(0, 1) == 1) ? $urandom() : 32'd0;
                    bus_wr(16'(h * 4), d);
                end
                2, 3, 4: begin
                    if ($urandom_range(0, 1) == 1)
                        bus_wr(16'(16'h4004 + h * 8), m_time[63:32] + 32'($urandom_range(0, 1)));
                    else
                        bus_wr(16'(16'h4000 + h * 8), m_time[31:0] + 32'($urandom_range(0, 12)));
                end
                5: begin
                    if ($urandom_range(0, 3) == 0) bus_wr(16'hBFFC, 32'd0);
                    else bus_wr(16'hBFF8, 32'($urandom_range(0, 1000)));
                end
                6: bus_wr(16'(16'hC000 + ($urandom_range(0, 16'h3FFF) & 16'hFFFC)), $urandom());
                default: rd_chk(16'($urandom_range(0, 16'hFFFF)), "R3");
            endcase
            irq_chk("R7");
        end
        b_tick = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule